// File: doc/BRIEF.md
# Output Setpoint Slew Controller

This block produces the 7-bit reference code that feeds the output-voltage DAC of a step-down converter. The output voltage is 1.000 V plus 6.25 mV for every code step above 64, so code 80 means 1.100 V. Two stored codes are held outside the block. A select pin picks which one is the live target. The block then moves its output code toward that target.

Upward moves are rate limited. Each step adds one LSB, and the time between steps is a base prescaler period shifted left by a 3-bit slew code. The eight settings therefore form a binary-weighted series of rates. Downward moves do not ramp. The code jumps straight to the new target, and switching is held off until an external comparator reports that the output has dropped to the new level. Each direction has its own in-progress flag.

When the run request rises, a soft-start begins. The code starts at 64 and climbs at the fastest rate, whatever the slew code is. Both direction flags stay high until soft-start ends. If the target moves during a ramp, the block looks at it again on the next edge.

Top module: `sp_slew_ctrl`

## Requirements
- R1: A selected code below 64 is treated as 64. The output code is never below 64.
- R2: When `bank_sel` is 0 the target is `bank0_code`, and when it is 1 the target is `bank1_code`. The bank that is not selected has no effect on the output.
- R3: While rising, the code increases by exactly one LSB per step. Steps are spaced BASE_DIV << `slew_sel` clock cycles apart, where `slew_sel` 0 is the fastest and each higher value doubles the spacing.
- R4: `rise_busy` is 1 for the whole upward transition. It clears in the same cycle that the code reaches the target, and `sw_inhibit` stays 0 while rising.
- R5: If the target falls below the current code, the code equals the target one clock later. In that same cycle `fall_busy` and `sw_inhibit` become 1 and `rise_busy` is 0.
- R6: `fall_busy` and `sw_inhibit` stay 1 while `vout_low` is 0. They clear one clock after `vout_low` is seen high.
- R7: A rising `run_req` starts soft-start. During soft-start `ss_active`, `rise_busy` and `fall_busy` are all 1, the code starts at 64, and steps come every BASE_DIV cycles whatever `slew_sel` holds.
- R8: If the target drops below the code in the middle of a ramp, the block jumps to the new target and changes to downward handling on the next clock.
- R9: One clock after `run_req` goes low, the code is 64 and all flags are 0. While `run_req` is low, changes to the stored codes have no effect.
- R10: If the target rises above the code during a downward wait, `fall_busy` and `sw_inhibit` drop and `rise_busy` rises on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_req | input | 1 | Regulator enable; its rising edge starts soft-start |
| bank_sel | input | 1 | Selects which stored code is the target |
| bank0_code | input | 7 | Stored code used when `bank_sel` is 0 |
| bank1_code | input | 7 | Stored code used when `bank_sel` is 1 |
| slew_sel | input | 3 | Upward step-spacing exponent |
| vout_low | input | 1 | Comparator: output is at or below the target |
| dac_code | output | 7 | Reference code sent to the DAC |
| rise_busy | output | 1 | Upward transition or soft-start in progress |
| fall_busy | output | 1 | Downward transition or soft-start in progress |
| sw_inhibit | output | 1 | Switching held off while the output discharges |
| ss_active | output | 1 | Soft-start in progress |

## Verification
The hardest case to reach is a reversal in the middle of a ramp. The target must drop below a code that is still rising, and then rise again while the block is waiting for the comparator. Both target changes have to land between two steps. The stimulus uses the fastest slew setting and counts code changes at the ports to reach a known intermediate code. It then rewrites the selected stored code on a falling edge and holds `vout_low` low, so the downward wait stays open when the upward target is applied.

// File: rtl/sp_slew_pkg.sv
package sp_slew_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SOFT,
      ST_HOLD,
      ST_RISE,
      ST_FALL
   } sp_state_t;

   function automatic logic is_ramping(input sp_state_t s);
      return (s == ST_SOFT) || (s == ST_RISE);
   endfunction

endpackage

// File: rtl/sp_target_sel.sv
module sp_target_sel #(
   parameter int CODE_W   = 7,
   parameter int MIN_CODE = 64,
   parameter bit CLAMP_EN = 1'b1
) (
   input  logic              bank_sel,
   input  logic [CODE_W-1:0] bank0_code,
   input  logic [CODE_W-1:0] bank1_code,
   output logic [CODE_W-1:0] tgt_code
);
   localparam logic [CODE_W-1:0] FLOOR = CODE_W'(MIN_CODE);

   logic [CODE_W-1:0] raw_code;

   assign raw_code = bank_sel ? bank1_code : bank0_code;

   generate
      if (CLAMP_EN) begin : g_clamp
         assign tgt_code = (raw_code < FLOOR) ? FLOOR : raw_code;
      end else begin : g_pass
         assign tgt_code = raw_code;
      end
   endgenerate

endmodule

// File: rtl/sp_step_timer.sv
module sp_step_timer #(
   parameter int BASE_DIV = 4,
   parameter int SLEW_W   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              fast,
   input  logic [SLEW_W-1:0] slew_sel,
   output logic              step_tick
);
   localparam int MAX_SHIFT = (1 << SLEW_W) - 1;
   localparam int MAX_LIM   = BASE_DIV << MAX_SHIFT;
   localparam int CNT_W     = $clog2(MAX_LIM + 1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] lim;
   logic [SLEW_W-1:0] shift_amt;

   assign shift_amt = fast ? '0 : slew_sel;
   assign lim       = CNT_W'(BASE_DIV) << shift_amt;
   assign step_tick = run && (cnt_q >= (lim - CNT_W'(1)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run || step_tick) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

endmodule

// File: rtl/sp_code_seq.sv
module sp_code_seq
   import sp_slew_pkg::*;
#(
   parameter int CODE_W   = 7,
   parameter int MIN_CODE = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_req,
   input  logic [CODE_W-1:0] tgt_code,
   input  logic              step_tick,
   input  logic              vout_low,
   output sp_state_t         state,
   output logic [CODE_W-1:0] code
);
   localparam logic [CODE_W-1:0] FLOOR = CODE_W'(MIN_CODE);

   sp_state_t         st_q, st_d;
   logic [CODE_W-1:0] code_q, code_d;
   logic [CODE_W-1:0] code_inc;

   assign code_inc = code_q + CODE_W'(1);

   always_comb begin
      st_d   = st_q;
      code_d = code_q;
      if (!run_req) begin
         st_d   = ST_IDLE;
         code_d = FLOOR;
      end else if (st_q == ST_IDLE) begin
         st_d   = ST_SOFT;
         code_d = FLOOR;
      end else if (tgt_code < code_q) begin
         st_d   = ST_FALL;
         code_d = tgt_code;
      end else if (tgt_code > code_q) begin
         if (is_ramping(st_q)) begin
            if (step_tick) begin
               code_d = code_inc;
               if (code_inc == tgt_code) begin
                  st_d = ST_HOLD;
               end
            end
         end else begin
            st_d = ST_RISE;
         end
      end else begin
         if (st_q == ST_FALL) begin
            if (vout_low) begin
               st_d = ST_HOLD;
            end
         end else begin
            st_d = ST_HOLD;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         code_q <= FLOOR;
      end else begin
         st_q   <= st_d;
         code_q <= code_d;
      end
   end

   assign state = st_q;
   assign code  = code_q;

endmodule

// File: rtl/sp_slew_ctrl.sv
module sp_slew_ctrl
   import sp_slew_pkg::*;
#(
   parameter int CODE_W   = 7,
   parameter int MIN_CODE = 64,
   parameter int BASE_DIV = 4,
   parameter int SLEW_W   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_req,
   input  logic              bank_sel,
   input  logic [CODE_W-1:0] bank0_code,
   input  logic [CODE_W-1:0] bank1_code,
   input  logic [SLEW_W-1:0] slew_sel,
   input  logic              vout_low,
   output logic [CODE_W-1:0] dac_code,
   output logic              rise_busy,
   output logic              fall_busy,
   output logic              sw_inhibit,
   output logic              ss_active
);
   generate
      if (MIN_CODE < 0 || MIN_CODE >= (1 << CODE_W)) begin : g_bad_min
         $error("MIN_CODE does not fit in CODE_W bits");
      end
      if (BASE_DIV < 1) begin : g_bad_div
         $error("BASE_DIV must be at least 1");
      end
      if (SLEW_W < 1 || SLEW_W > 4) begin : g_bad_slew
         $error("SLEW_W must be between 1 and 4");
      end
   endgenerate

   logic [CODE_W-1:0] tgt_code;
   logic              step_tick;
   sp_state_t         state;

   sp_target_sel #(
      .CODE_W   (CODE_W),
      .MIN_CODE (MIN_CODE),
      .CLAMP_EN (1'b1)
   ) tsel_i (
      .bank_sel   (bank_sel),
      .bank0_code (bank0_code),
      .bank1_code (bank1_code),
      .tgt_code   (tgt_code)
   );

   sp_step_timer #(
      .BASE_DIV (BASE_DIV),
      .SLEW_W   (SLEW_W)
   ) tmr_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (is_ramping(state)),
      .fast      (state == ST_SOFT),
      .slew_sel  (slew_sel),
      .step_tick (step_tick)
   );

   sp_code_seq #(
      .CODE_W   (CODE_W),
      .MIN_CODE (MIN_CODE)
   ) seq_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_req   (run_req),
      .tgt_code  (tgt_code),
      .step_tick (step_tick),
      .vout_low  (vout_low),
      .state     (state),
      .code      (dac_code)
   );

   assign ss_active  = (state == ST_SOFT);
   assign rise_busy  = is_ramping(state);
   assign fall_busy  = (state == ST_SOFT) || (state == ST_FALL);
   assign sw_inhibit = (state == ST_FALL);

endmodule

// File: rtl/sp_slew_ctrl_chk.sv
module sp_slew_ctrl_chk #(
   parameter int CODE_W   = 7,
   parameter int MIN_CODE = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              run_req,
   input logic [CODE_W-1:0] dac_code,
   input logic              rise_busy,
   input logic              fall_busy,
   input logic              sw_inhibit,
   input logic              ss_active
);
   logic past_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   AST_CODE_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      dac_code >= CODE_W'(MIN_CODE)); // R1

   AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && rise_busy && $past(rise_busy) && (dac_code > $past(dac_code)))
      |-> (dac_code == $past(dac_code) + CODE_W'(1))); // R3

   AST_RISE_NO_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
      !(rise_busy && sw_inhibit)); // R4

   AST_SS_START: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $rose(ss_active)) |-> (dac_code == CODE_W'(MIN_CODE) && fall_busy)); // R7

   AST_OFF_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      !run_req |=> (dac_code == CODE_W'(MIN_CODE) && !rise_busy && !fall_busy)); // R9

endmodule

bind sp_slew_ctrl sp_slew_ctrl_chk #(
   .CODE_W   (CODE_W),
   .MIN_CODE (MIN_CODE)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .run_req    (run_req),
   .dac_code   (dac_code),
   .rise_busy  (rise_busy),
   .fall_busy  (fall_busy),
   .sw_inhibit (sw_inhibit),
   .ss_active  (ss_active)
);

// File: tb/sp_slew_ctrl_tb.sv
module sp_slew_ctrl_tb_top;
   localparam int BASE = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       run_req = 1'b0;
   logic       bank_sel = 1'b0;
   logic [6:0] bank0_code = 7'd70;
   logic [6:0] bank1_code = 7'd74;
   logic [2:0] slew_sel = 3'd0;
   logic       vout_low = 1'b0;
   logic [6:0] dac_code;
   logic       rise_busy, fall_busy, sw_inhibit, ss_active;

   int n_chk = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   sp_slew_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .run_req(run_req), .bank_sel(bank_sel),
      .bank0_code(bank0_code), .bank1_code(bank1_code), .slew_sel(slew_sel),
      .vout_low(vout_low), .dac_code(dac_code), .rise_busy(rise_busy),
      .fall_busy(fall_busy), .sw_inhibit(sw_inhibit), .ss_active(ss_active)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wait_change(output int n, input int limit);
      logic [6:0] prev;
      prev = dac_code;
      n = 0;
      while (n < limit) begin
         @(negedge clk);
         n++;
         if (dac_code != prev) break;
      end
   endtask

   task automatic t_reset();
      check("R9 reset code", dac_code, 64);
      check("R9 reset flags", {rise_busy, fall_busy, sw_inhibit, ss_active}, 0);
   endtask

   task automatic t_softstart();
      int n;
      slew_sel = 3'd7;
      bank_sel = 1'b0;
      bank0_code = 7'd70;
      run_req = 1'b1;
      cyc(1);
      check("R7 ss flags", {ss_active, rise_busy, fall_busy, sw_inhibit}, 4'b1110);
      check("R7 ss start code", dac_code, 64);
      wait_change(n, 100);
      check("R7 ss step spacing", n, BASE);
      check("R7 ss first step", dac_code, 65);
      for (int k = 0; k < 5; k++) begin
         wait_change(n, 100);
         check("R7 ss spacing", n, BASE);
      end
      check("R4 ss end code", dac_code, 70);
      check("R4 ss end flags", {ss_active, rise_busy, fall_busy}, 0);
   endtask

   task automatic t_bank_rise();
      int n;
      slew_sel = 3'd2;
      bank1_code = 7'd74;
      bank_sel = 1'b1;
      wait_change(n, 200);
      check("R2 bank1 rise starts", dac_code, 71);
      check("R4 rise flag", {rise_busy, sw_inhibit}, 2'b10);
      for (int k = 0; k < 3; k++) begin
         wait_change(n, 200);
         check("R3 slew2 spacing", n, BASE << 2);
         check("R3 one lsb", dac_code, 72 + k);
      end
      check("R4 rise done flag", rise_busy, 0);
      bank0_code = 7'd100;
      cyc(40);
      check("R2 unselected bank ignored", dac_code, 74);
      check("R2 unselected bank flags", {rise_busy, fall_busy}, 0);
      bank0_code = 7'd70;
   endtask

   task automatic t_fall();
      bank_sel = 1'b0;
      cyc(1);
      check("R5 jump code", dac_code, 70);
      check("R5 fall flags", {rise_busy, fall_busy, sw_inhibit}, 3'b011);
      cyc(10);
      check("R6 wait holds", {fall_busy, sw_inhibit}, 2'b11);
      vout_low = 1'b1;
      cyc(1);
      check("R6 release", {fall_busy, sw_inhibit}, 0);
      check("R6 code kept", dac_code, 70);
      vout_low = 1'b0;
   endtask

   task automatic t_clamp();
      bank0_code = 7'd10;
      cyc(1);
      check("R1 clamp code", dac_code, 64);
      check("R1 clamp falls", fall_busy, 1);
      vout_low = 1'b1;
      cyc(1);
      vout_low = 1'b0;
      cyc(5);
      check("R1 clamp stays", dac_code, 64);
   endtask

   task automatic t_reverse();
      int n;
      slew_sel = 3'd0;
      bank0_code = 7'd80;
      for (int k = 0; k < 3; k++) wait_change(n, 100);
      check("R3 slew0 spacing", n, BASE);
      check("R8 mid ramp code", dac_code, 67);
      bank0_code = 7'd66;
      cyc(1);
      check("R8 reversal jump", dac_code, 66);
      check("R8 reversal flags", {rise_busy, fall_busy, sw_inhibit}, 3'b011);
      cyc(3);
      bank0_code = 7'd68;
      cyc(1);
      check("R10 fall to rise flags", {rise_busy, fall_busy, sw_inhibit}, 3'b100);
      wait_change(n, 100);
      wait_change(n, 100);
      check("R10 reaches target", dac_code, 68);
      check("R10 done", rise_busy, 0);
   endtask

   task automatic t_disable();
      run_req = 1'b0;
      cyc(1);
      check("R9 off code", dac_code, 64);
      check("R9 off flags", {rise_busy, fall_busy, sw_inhibit, ss_active}, 0);
      bank0_code = 7'd120;
      cyc(10);
      check("R9 off ignores banks", dac_code, 64);
   endtask

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      t_reset();
      t_softstart();
      t_bank_rise();
      t_fall();
      t_clamp();
      t_reverse();
      t_disable();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule